// File: doc/BRIEF.md
# Two-Level DMA Address Generator

This block works out the byte addresses for one DMA channel. A transfer (a block) is made of a programmable number of microblocks, and each microblock is made of a programmable number of data elements. Each accepted element produces one source address and one destination address. Each side can advance its address through memory or hold it fixed on a single register such as a peripheral FIFO.

Software-facing logic places the start addresses, the element size, both counts, the address modes and four signed strides on the configuration inputs, then pulses `start`. The block captures that configuration and presents address pairs on a valid/ready output. It marks the last element of every microblock and the last element of the block. After the final pair has been taken it pulses `done`. The captured configuration cannot change until the block has finished.

Top module: `dma_agen`

## Requirements
- R1: After reset `busy`, `out_valid` and `done` are low.
- R2: A `start` pulse while idle captures the configuration. From the next cycle `busy` and `out_valid` are high, and the first pair is the source and destination base addresses.
- R3: In increment mode the next address inside a microblock is the previous address plus the element size plus the sign-extended 16-bit element stride. Element size code 0 means 1 byte, code 1 means 2 bytes, and codes 2 and 3 mean 4 bytes.
- R4: In fixed mode (incr input 0) a side's address does not change from one element to the next within a microblock.
- R5: Across a microblock boundary the next address is the previous address plus that side's element step (zero in fixed mode), plus the sign-extended microblock stride when that side's jump enable is 1. The jump applies in both modes.
- R6: `out_last_ub` is high exactly on the final element of each microblock. `out_last_blk` is high exactly on the final element of the block, together with `out_last_ub`.
- R7: An element count or microblock count of zero behaves as a count of one.
- R8: While `out_valid` is high and `out_ready` is low, the address pair and both flags hold steady.
- R9: `done` is high for exactly the one cycle after the last pair is accepted. `busy` is low in the cycle after that.
- R10: A `start` pulse while `busy` is high has no effect on the address sequence.
- R11: Addresses wrap modulo 2^32 in both directions without any error indication.
- R12: Changes on the configuration inputs after `start` do not affect the transfer in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a block with the current configuration |
| cfg_src_base | input | 32 | Source start address |
| cfg_dst_base | input | 32 | Destination start address |
| cfg_elem_size | input | 2 | Element size code (0:1, 1:2, 2/3:4 bytes) |
| cfg_elem_count | input | 24 | Elements per microblock (0 means 1) |
| cfg_ublk_count | input | 16 | Microblocks per block (0 means 1) |
| cfg_src_incr | input | 1 | Source mode: 1 increment, 0 fixed |
| cfg_dst_incr | input | 1 | Destination mode: 1 increment, 0 fixed |
| cfg_src_estride | input | 16 | Signed extra source step per element |
| cfg_dst_estride | input | 16 | Signed extra destination step per element |
| cfg_src_ustride | input | 16 | Signed source jump at microblock boundary |
| cfg_dst_ustride | input | 16 | Signed destination jump at microblock boundary |
| cfg_src_ujump | input | 1 | Apply source microblock jump |
| cfg_dst_ujump | input | 1 | Apply destination microblock jump |
| out_ready | input | 1 | Consumer accepts the presented pair |
| busy | output | 1 | A block is in progress |
| done | output | 1 | One-cycle end-of-block pulse |
| out_valid | output | 1 | Address pair is presented |
| out_src | output | 32 | Source byte address |
| out_dst | output | 32 | Destination byte address |
| out_last_ub | output | 1 | Final element of the current microblock |
| out_last_blk | output | 1 | Final element of the block |

## Verification
The bench builds the block with its default widths: 32-bit addresses, 24-bit element counts, 16-bit microblock counts and 16-bit strides. It keeps each block small, with element counts of 0, 1 and 3 and microblock counts of 0, 2 and 3. At that size it can sweep every element size code, both modes on each side and both jump settings. It checks every accepted pair against a closed-form product of the indices and the steps. The consumer's ready line is throttled pseudo-randomly, so stalls fall on ordinary elements, on microblock ends and on the final element. Separate runs place bases near the top and bottom of the address space, so the wrap in both directions is reached in a few elements.

// File: rtl/dma_agen_pkg.sv
package dma_agen_pkg;

  parameter int unsigned ADDR_W   = 32;
  parameter int unsigned ECNT_W   = 24;
  parameter int unsigned UCNT_W   = 16;
  parameter int unsigned STRIDE_W = 16;
  parameter int unsigned ESZ_W    = 2;
  parameter int unsigned NSIDE    = 2;

  localparam int unsigned SIDE_SRC = 0;
  localparam int unsigned SIDE_DST = 1;
  localparam int unsigned EXT_W    = ADDR_W - STRIDE_W;

  typedef logic [ADDR_W-1:0] addr_t;

  typedef enum logic [1:0] {
    AG_IDLE = 2'd0,
    AG_RUN  = 2'd1,
    AG_FIN  = 2'd2
  } agen_state_e;

  // Per-side settings captured at start; both steps are resolved up front.
  typedef struct packed {
    logic  incr;
    addr_t step;
    addr_t ub_step;
  } side_cfg_t;

  function automatic addr_t sext_stride(input logic [STRIDE_W-1:0] s);
    return {{EXT_W{s[STRIDE_W-1]}}, s};
  endfunction

  function automatic addr_t elem_bytes(input logic [ESZ_W-1:0] code);
    addr_t b;
    case (code)
      2'd0:    b = addr_t'(1);
      2'd1:    b = addr_t'(2);
      default: b = addr_t'(4);
    endcase
    return b;
  endfunction

  function automatic side_cfg_t make_side_cfg(
    input logic                incr,
    input logic [ESZ_W-1:0]    code,
    input logic [STRIDE_W-1:0] estride,
    input logic                ujump,
    input logic [STRIDE_W-1:0] ustride
  );
    side_cfg_t c;
    c.incr    = incr;
    c.step    = incr ? (elem_bytes(code) + sext_stride(estride)) : '0;
    c.ub_step = c.step + (ujump ? sext_stride(ustride) : '0);
    return c;
  endfunction

  function automatic addr_t advance_addr(
    input addr_t     a,
    input logic      at_ub_end,
    input side_cfg_t c
  );
    return a + (at_ub_end ? c.ub_step : c.step);
  endfunction

  function automatic logic [ECNT_W-1:0] elem_last_index(input logic [ECNT_W-1:0] n);
    return (n == '0) ? '0 : n - 1'b1;
  endfunction

  function automatic logic [UCNT_W-1:0] ublk_last_index(input logic [UCNT_W-1:0] n);
    return (n == '0) ? '0 : n - 1'b1;
  endfunction

endpackage

// File: rtl/dma_agen_ctrl.sv
module dma_agen_ctrl
  import dma_agen_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic accept,
  input  logic blk_end,
  output logic load,
  output logic busy,
  output logic valid,
  output logic done
);

  agen_state_e state_q, state_d;

  assign load = start && (state_q == AG_IDLE);

  always_comb begin
    state_d = state_q;
    case (state_q)
      AG_IDLE: if (load) state_d = AG_RUN;
      AG_RUN:  if (accept && blk_end) state_d = AG_FIN;
      AG_FIN:  state_d = AG_IDLE;
      default: state_d = AG_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= AG_IDLE;
    else        state_q <= state_d;
  end

  assign busy  = (state_q != AG_IDLE);
  assign valid = (state_q == AG_RUN);
  assign done  = (state_q == AG_FIN);

endmodule

// File: rtl/dma_agen_idx.sv
module dma_agen_idx #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         inc,
  input  logic [W-1:0] last_idx,
  output logic         at_last
);

  logic [W-1:0] idx_q;

  assign at_last = (idx_q == last_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     idx_q <= '0;
    else if (clear) idx_q <= '0;
    else if (inc)   idx_q <= at_last ? '0 : idx_q + 1'b1;
  end

endmodule

// File: rtl/dma_agen_side.sv
module dma_agen_side
  import dma_agen_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      load,
  input  logic      advance,
  input  logic      at_ub_end,
  input  addr_t     base,
  input  side_cfg_t cfg,
  output addr_t     addr
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr <= '0;
    else if (load)    addr <= base;
    else if (advance) addr <= advance_addr(addr, at_ub_end, cfg);
  end

endmodule

// File: rtl/dma_agen.sv
module dma_agen
  import dma_agen_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [ADDR_W-1:0]   cfg_src_base,
  input  logic [ADDR_W-1:0]   cfg_dst_base,
  input  logic [ESZ_W-1:0]    cfg_elem_size,
  input  logic [ECNT_W-1:0]   cfg_elem_count,
  input  logic [UCNT_W-1:0]   cfg_ublk_count,
  input  logic                cfg_src_incr,
  input  logic                cfg_dst_incr,
  input  logic [STRIDE_W-1:0] cfg_src_estride,
  input  logic [STRIDE_W-1:0] cfg_dst_estride,
  input  logic [STRIDE_W-1:0] cfg_src_ustride,
  input  logic [STRIDE_W-1:0] cfg_dst_ustride,
  input  logic                cfg_src_ujump,
  input  logic                cfg_dst_ujump,
  input  logic                out_ready,
  output logic                busy,
  output logic                done,
  output logic                out_valid,
  output logic [ADDR_W-1:0]   out_src,
  output logic [ADDR_W-1:0]   out_dst,
  output logic                out_last_ub,
  output logic                out_last_blk
);

  // Named internal events, also observed by the bound checker.
  logic load;
  logic accept;
  logic ub_end;
  logic blk_end;
  logic elem_at_last;
  logic ublk_at_last;

  logic [ECNT_W-1:0] elem_last_q;
  logic [UCNT_W-1:0] ublk_last_q;

  side_cfg_t side_cfg_d [NSIDE];
  side_cfg_t side_cfg_q [NSIDE];
  addr_t     side_base  [NSIDE];
  addr_t     side_addr  [NSIDE];

  logic  src_incr_q, dst_incr_q;
  addr_t src_step_q, dst_step_q;

  always_comb begin
    side_cfg_d[SIDE_SRC] = make_side_cfg(cfg_src_incr, cfg_elem_size, cfg_src_estride,
                                         cfg_src_ujump, cfg_src_ustride);
    side_cfg_d[SIDE_DST] = make_side_cfg(cfg_dst_incr, cfg_elem_size, cfg_dst_estride,
                                         cfg_dst_ujump, cfg_dst_ustride);
    side_base[SIDE_SRC]  = cfg_src_base;
    side_base[SIDE_DST]  = cfg_dst_base;
  end

  // Configuration is captured once per block and frozen until the next load.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      elem_last_q <= '0;
      ublk_last_q <= '0;
    end else if (load) begin
      elem_last_q <= elem_last_index(cfg_elem_count);
      ublk_last_q <= ublk_last_index(cfg_ublk_count);
    end
  end

  dma_agen_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .accept  (accept),
    .blk_end (blk_end),
    .load    (load),
    .busy    (busy),
    .valid   (out_valid),
    .done    (done)
  );

  assign accept = out_valid && out_ready;

  dma_agen_idx #(.W(ECNT_W)) u_elem_idx (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (load),
    .inc      (accept),
    .last_idx (elem_last_q),
    .at_last  (elem_at_last)
  );

  dma_agen_idx #(.W(UCNT_W)) u_ublk_idx (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (load),
    .inc      (accept && ub_end),
    .last_idx (ublk_last_q),
    .at_last  (ublk_at_last)
  );

  assign ub_end  = out_valid && elem_at_last;
  assign blk_end = ub_end && ublk_at_last;

  for (genvar g = 0; g < NSIDE; g++) begin : g_side
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    side_cfg_q[g] <= '0;
      else if (load) side_cfg_q[g] <= side_cfg_d[g];
    end

    dma_agen_side u_side (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .advance   (accept),
      .at_ub_end (ub_end),
      .base      (side_base[g]),
      .cfg       (side_cfg_q[g]),
      .addr      (side_addr[g])
    );
  end

  assign out_src      = side_addr[SIDE_SRC];
  assign out_dst      = side_addr[SIDE_DST];
  assign out_last_ub  = ub_end;
  assign out_last_blk = blk_end;

  assign src_incr_q = side_cfg_q[SIDE_SRC].incr;
  assign dst_incr_q = side_cfg_q[SIDE_DST].incr;
  assign src_step_q = side_cfg_q[SIDE_SRC].step;
  assign dst_step_q = side_cfg_q[SIDE_DST].step;

endmodule

// File: rtl/dma_agen_chk.sv
module dma_agen_chk
  import dma_agen_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              out_valid,
  input logic              out_ready,
  input logic [ADDR_W-1:0] out_src,
  input logic [ADDR_W-1:0] out_dst,
  input logic              out_last_ub,
  input logic              out_last_blk,
  input logic              accept,
  input logic              ub_end,
  input logic              blk_end,
  input logic              src_incr,
  input logic              dst_incr,
  input logic [ADDR_W-1:0] src_step,
  input logic [ADDR_W-1:0] dst_step,
  input logic [ECNT_W-1:0] elem_last,
  input logic [UCNT_W-1:0] ublk_last
);

  AST_VALID_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> busy); // R2

  AST_INC_STEP_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !ub_end |=> out_src == $past(out_src) + $past(src_step)); // R3

  AST_INC_STEP_DST: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !ub_end |=> out_dst == $past(out_dst) + $past(dst_step)); // R3

  AST_FIXED_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !ub_end && !src_incr |=> $stable(out_src)); // R4

  AST_FIXED_DST: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !ub_end && !dst_incr |=> $stable(out_dst)); // R4

  AST_BLK_WITH_UB: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_last_blk |-> out_last_ub); // R6

  AST_HOLD_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_src) && $stable(out_dst)
      && $stable(out_last_ub) && $stable(out_last_blk)); // R8

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    accept && blk_end |=> done && !out_valid); // R9

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy); // R9

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(elem_last) && $stable(ublk_last) && $stable(src_step)
      && $stable(dst_step)); // R10

endmodule

bind dma_agen dma_agen_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .busy         (busy),
  .done         (done),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .out_src      (out_src),
  .out_dst      (out_dst),
  .out_last_ub  (out_last_ub),
  .out_last_blk (out_last_blk),
  .accept       (accept),
  .ub_end       (ub_end),
  .blk_end      (blk_end),
  .src_incr     (src_incr_q),
  .dst_incr     (dst_incr_q),
  .src_step     (src_step_q),
  .dst_step     (dst_step_q),
  .elem_last    (elem_last_q),
  .ublk_last    (ublk_last_q)
);

// File: tb/tb_dma_agen.sv
module tb_dma_agen;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] cfg_src_base = '0, cfg_dst_base = '0;
  logic [1:0]  cfg_elem_size = '0;
  logic [23:0] cfg_elem_count = '0;
  logic [15:0] cfg_ublk_count = '0;
  logic        cfg_src_incr = 1'b0, cfg_dst_incr = 1'b0;
  logic [15:0] cfg_src_estride = '0, cfg_dst_estride = '0;
  logic [15:0] cfg_src_ustride = '0, cfg_dst_ustride = '0;
  logic        cfg_src_ujump = 1'b0, cfg_dst_ujump = 1'b0;
  logic        out_ready = 1'b0;
  logic        busy, done, out_valid, out_last_ub, out_last_blk;
  logic [31:0] out_src, out_dst;

  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;
  logic [7:0] lfsr = 8'h5b;

  localparam int WATCHDOG = 150000;

  always #5 clk = ~clk;

  dma_agen dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_src_base(cfg_src_base), .cfg_dst_base(cfg_dst_base),
    .cfg_elem_size(cfg_elem_size), .cfg_elem_count(cfg_elem_count),
    .cfg_ublk_count(cfg_ublk_count),
    .cfg_src_incr(cfg_src_incr), .cfg_dst_incr(cfg_dst_incr),
    .cfg_src_estride(cfg_src_estride), .cfg_dst_estride(cfg_dst_estride),
    .cfg_src_ustride(cfg_src_ustride), .cfg_dst_ustride(cfg_dst_ustride),
    .cfg_src_ujump(cfg_src_ujump), .cfg_dst_ujump(cfg_dst_ujump),
    .out_ready(out_ready), .busy(busy), .done(done), .out_valid(out_valid),
    .out_src(out_src), .out_dst(out_dst),
    .out_last_ub(out_last_ub), .out_last_blk(out_last_blk)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Closed form: base + m*(L*step + jump) + e*step, all modulo 2^32.
  function automatic logic [31:0] exp_addr(input logic [31:0] base, input bit incr,
      input int esz, input logic [15:0] es, input logic [15:0] us, input bit uj,
      input int L, input int m, input int e);
    logic [31:0] step, jump;
    step = incr ? (32'((esz == 0) ? 1 : (esz == 1) ? 2 : 4) + {{16{es[15]}}, es}) : 32'd0;
    jump = uj ? {{16{us[15]}}, us} : 32'd0;
    return base + 32'(m) * (32'(L) * step + jump) + 32'(e) * step;
  endfunction

  task automatic run_block(input logic [31:0] sa, input logic [31:0] da, input int esz,
      input bit sm, input bit dm, input int L, input int M,
      input logic [15:0] se, input logic [15:0] de, input logic [15:0] su,
      input logic [15:0] du, input bit sj, input bit dj,
      input bit mid_start, input string tag_override);
    int Le, Me, total, count, e, m, wd;
    bit stalled, rdy;
    logic [31:0] h_src, h_dst;
    logic h_ub, h_blk;
    string tag;
    Le = (L == 0) ? 1 : L;
    Me = (M == 0) ? 1 : M;
    total = Le * Me;
    count = 0; e = 0; m = 0; wd = 0; stalled = 0;
    h_src = '0; h_dst = '0; h_ub = 0; h_blk = 0;
    @(negedge clk);
    cfg_src_base = sa; cfg_dst_base = da; cfg_elem_size = 2'(esz);
    cfg_elem_count = 24'(L); cfg_ublk_count = 16'(M);
    cfg_src_incr = sm; cfg_dst_incr = dm;
    cfg_src_estride = se; cfg_dst_estride = de;
    cfg_src_ustride = su; cfg_dst_ustride = du;
    cfg_src_ujump = sj; cfg_dst_ujump = dj;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(out_valid && busy, "R2", "valid and busy after start", {30'd0, busy, out_valid}, 32'd3);
    // R12: scramble the configuration inputs for the rest of the block
    cfg_src_base = ~sa; cfg_dst_base = sa ^ da; cfg_elem_size = 2'(esz + 1);
    cfg_elem_count = 24'd7; cfg_ublk_count = 16'd5;
    cfg_src_incr = ~sm; cfg_dst_incr = ~dm;
    cfg_src_estride = ~se; cfg_dst_estride = de + 16'd9;
    cfg_src_ustride = ~su; cfg_dst_ustride = ~du;
    cfg_src_ujump = ~sj; cfg_dst_ujump = ~dj;
    while (count < total && wd < 2000) begin
      start = 1'b0;
      if (stalled) begin
        chk(out_valid && out_src == h_src && out_dst == h_dst && out_last_ub == h_ub
            && out_last_blk == h_blk, "R8", "pair held during stall", out_src, h_src);
      end
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      rdy = lfsr[0] | lfsr[2];
      out_ready = rdy;
      if (out_valid && rdy) begin
        if (tag_override != "") tag = tag_override;
        else if (e == 0 && m > 0) tag = "R5";
        else tag = "R3";
        chk(out_src == exp_addr(sa, sm, esz, se, su, sj, Le, m, e),
            sm ? tag : ((e == 0 && m > 0) ? "R5" : "R4"), "source address (R12 config held)",
            out_src, exp_addr(sa, sm, esz, se, su, sj, Le, m, e));
        chk(out_dst == exp_addr(da, dm, esz, de, du, dj, Le, m, e),
            dm ? tag : ((e == 0 && m > 0) ? "R5" : "R4"), "destination address (R12 config held)",
            out_dst, exp_addr(da, dm, esz, de, du, dj, Le, m, e));
        chk(out_last_ub == (e == Le - 1), (L == 0) ? "R7" : "R6", "last_in_microblock",
            {31'd0, out_last_ub}, {31'd0, (e == Le - 1)});
        chk(out_last_blk == (count == total - 1), (M == 0) ? "R7" : "R6", "last_in_block",
            {31'd0, out_last_blk}, {31'd0, (count == total - 1)});
        count++;
        if (e == Le - 1) begin e = 0; m++; end
        else e++;
        if (mid_start && count == 1) start = 1'b1; // R10: ignored while busy
      end
      stalled = out_valid && !rdy;
      h_src = out_src; h_dst = out_dst; h_ub = out_last_ub; h_blk = out_last_blk;
      @(negedge clk);
      wd++;
    end
    start = 1'b0;
    out_ready = 1'b0;
    chk(count == total, (L == 0 || M == 0) ? "R7" : "R6", "elements accepted",
        32'(count), 32'(total));
    chk(done && !out_valid, mid_start ? "R10" : "R9", "done pulse after last accept",
        {30'd0, done, out_valid}, 32'd2);
    @(negedge clk);
    chk(!done && !busy && !out_valid, "R9", "idle after done",
        {29'd0, done, busy, out_valid}, 32'd0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == WATCHDOG) begin
      miscompares++;
      $display("FAIL R9 watchdog: actual=%0d expected<%0d cycles", cycles, WATCHDOG);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !out_valid && !done, "R1", "reset state",
        {29'd0, busy, out_valid, done}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !out_valid && !done, "R1", "idle after reset release",
        {29'd0, busy, out_valid, done}, 32'd0);

    for (int esz = 0; esz < 4; esz++)
      for (int sm = 0; sm < 2; sm++)
        for (int dm = 0; dm < 2; dm++)
          for (int li = 0; li < 3; li++)
            for (int mi = 0; mi < 3; mi++)
              for (int jn = 0; jn < 2; jn++)
                run_block(32'h1000_0000 + 32'(esz * 256), 32'h2000_0100, esz,
                          sm[0], dm[0], (li == 0) ? 0 : (li == 1) ? 1 : 3,
                          (mi == 0) ? 0 : (mi == 1) ? 2 : 3,
                          16'(esz * 3 - 4), 16'd7, 16'hffe0, 16'(64 + esz),
                          jn[0], ~jn[0], (esz == 1), "");

    // R11: upward wrap on source, downward wrap on destination
    run_block(32'hFFFF_FFF4, 32'h0000_0008, 2, 1'b1, 1'b1, 3, 3,
              16'd0, 16'hfff8, 16'd8, 16'hfff0, 1'b1, 1'b1, 1'b0, "R11");
    // R11 with fixed source and jumps wrapping on their own
    run_block(32'hFFFF_FFFE, 32'h0000_0001, 0, 1'b0, 1'b1, 2, 3,
              16'd0, 16'hfffc, 16'd3, 16'hffff, 1'b1, 1'b0, 1'b0, "R11");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule